// File: doc/BRIEF.md
# Latched multiplexed BCD accumulator

This block is the counting and read-out stage behind a dual-slope converter. While the count enable is high it adds one per clock to a decimal count held in a chain of divide-by-ten stages, one BCD digit per stage. When the active-low transfer input is low on a clock edge, the digits and an overflow flag are copied into a bank of holding registers. The counting side can then be cleared and start the next measurement while the display side keeps showing the previous result.

The display side walks through the held digits one scan slot at a time, starting with the most significant. Each digit appears on a shared 4-bit BCD bus together with a one-hot strobe that marks its display position, so a multiplexed seven-segment display can be driven from it. The scan repeats without end. The slot length is set by a parameter.

Top module: `bcd_scan_accum`

## Requirements
- R1: On a clock edge with rst_n low, the count digits and the count overflow flag clear to zero, and the scan restarts in the most significant slot, where digit_sel equals 1 << (DIGITS-1) with the slot timer at its start.
- R2: On each clock edge with rst_n high and count_en high, the count goes up by one in decimal, with digit 0 the least significant. While count_en is low the count holds.
- R3: A carry out of the most significant digit, which is the step from all nines to all zeros, sets a sticky count overflow flag. Only reset clears this flag.
- R4: On a clock edge with rst_n high and xfer_n low, the holding registers capture the current count digits and the overflow flag. ovf_out shows the held overflow flag (1 means overflow).
- R5: A low xfer_n on a clock edge where rst_n is also low is ignored, and the held values do not change.
- R6: Reset and counting leave the held digits and the held overflow flag unchanged until the next transfer.
- R7: The scan visits digit_sel bit DIGITS-1 first and then each lower bit in turn down to bit 0. It then returns to bit DIGITS-1 and continues repeating.
- R8: Each scan slot lasts exactly SLOT_CYCLES clock cycles, and exactly one bit of digit_sel is high.
- R9: In the same cycle that digit_sel bit k is high, bcd_out carries held digit k. That value is always in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of counter and scan |
| count_en | input | 1 | Count one per clock while high (run-down interval) |
| xfer_n | input | 1 | Active-low transfer of count into holding registers |
| bcd_out | output | 4 | BCD value of the digit currently scanned |
| digit_sel | output | DIGITS | One-hot digit strobe, bit DIGITS-1 is most significant |
| ovf_out | output | 1 | Held overflow flag from the last transfer |

## Verification
A wrong count shows up only after the next transfer, as a wrong BCD value in a particular digit slot. A bad carry or overflow bit also surfaces there, within one full scan frame of DIGITS*SLOT_CYCLES cycles. A fault in the scan state shows at once on digit_sel, as a slot of the wrong length, an order that skips a position, or more than one strobe high. Holding-register faults are exposed by comparing frames taken before and after a reset or an untransferred count, because the displayed value must not move.

// File: rtl/bcd_scan_pkg.sv
// Package: shared BCD types and constants for the scanned accumulator.
// Assumes: four-bit packed BCD digits holding values 0..9.
package bcd_scan_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_ZERO = 4'd0;
    localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/bcd_decade.sv
// Module: one divide-by-ten stage of the count chain.
// Steps its digit when inc_in is high and passes a carry on when it wraps.
// Assumes: the digit always holds a legal BCD value, 0..9.
module bcd_decade
    import bcd_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_in,
    output bcd_t digit,
    output logic carry_out
);
    // Carry leaves this stage when it is stepped while holding nine.
    assign carry_out = inc_in && (digit == BCD_NINE);

    // Digit register: clear on reset, step modulo ten when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit <= BCD_ZERO;
        end else if (inc_in) begin
            digit <= (digit == BCD_NINE) ? BCD_ZERO : bcd_t'(digit + 4'd1);
        end
    end
endmodule

// File: rtl/bcd_counter.sv
// Module: cascade of DIGITS decade stages plus a sticky overflow flag.
// The enable drives the carry into stage 0. A carry out of the top stage
// sets the overflow flag, and only reset clears it.
// Assumes: DIGITS >= 1.
module bcd_counter
    import bcd_scan_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  count_en,
    output bcd_t [DIGITS-1:0]     digits,
    output logic                  ovf
);
    logic [DIGITS:0] carry;

    assign carry[0] = count_en;

    // One decade per digit, carries chained from least significant upward.
    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        bcd_decade u_dec (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_in    (carry[g]),
            .digit     (digits[g]),
            .carry_out (carry[g+1])
        );
    end

    // Sticky overflow: set by the top carry, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (carry[DIGITS]) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/bcd_hold_bank.sv
// Module: holding registers between the count side and the display side.
// Captures the digits and the overflow flag on a transfer edge. Reset does
// not clear it, and a transfer during reset is ignored.
// Assumes: the power-up value of zero is acceptable before the first transfer.
module bcd_hold_bank
    import bcd_scan_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_n,
    input  bcd_t [DIGITS-1:0]     cnt_digits,
    input  logic                  cnt_ovf,
    output bcd_t [DIGITS-1:0]     held_digits,
    output logic                  held_ovf
);
    bcd_t [DIGITS-1:0] digits_q = '0;
    logic              ovf_q    = 1'b0;

    // Capture on transfer, but only when reset is not active.
    always_ff @(posedge clk) begin
        if (rst_n && !xfer_n) begin
            digits_q <= cnt_digits;
            ovf_q    <= cnt_ovf;
        end
    end

    assign held_digits = digits_q;
    assign held_ovf    = ovf_q;
endmodule

// File: rtl/bcd_scan_mux.sv
// Module: display scanner. A slot timer counts SLOT_CYCLES clocks per slot,
// and the digit index moves from the top digit down, then wraps. Its outputs
// are the one-hot strobe and the BCD value of the selected held digit.
// Assumes: DIGITS >= 1 and SLOT_CYCLES >= 1.
module bcd_scan_mux
    import bcd_scan_pkg::*;
#(
    parameter int DIGITS      = 4,
    parameter int SLOT_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bcd_t [DIGITS-1:0]     held_digits,
    output bcd_t                  bcd_out,
    output logic [DIGITS-1:0]     digit_sel
);
    localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [IDX_W-1:0]  IDX_TOP   = IDX_W'(DIGITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  idx_q;
    logic              slot_end;

    assign slot_end = (slot_q == SLOT_LAST);

    // Slot timer: restart on reset and at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n || slot_end) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    // Digit index: top digit after reset, step down each slot, wrap at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_TOP;
        end else if (slot_end) begin
            idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - IDX_W'(1);
        end
    end

    // Strobe and data leave together from the same index.
    assign digit_sel = DIGITS'(1) << idx_q;
    assign bcd_out   = held_digits[idx_q];
endmodule

// File: rtl/bcd_scan_accum.sv
// Module: top of the latched multiplexed BCD accumulator. It counts run-down
// clocks, holds the result on transfer, and scans the held digits out most
// significant first with a matching one-hot strobe.
// Assumes: xfer_n is asserted after count_en falls at the end of run-down.
module bcd_scan_accum
    import bcd_scan_pkg::*;
#(
    parameter int DIGITS      = 4,
    parameter int SLOT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              xfer_n,
    output logic [3:0]        bcd_out,
    output logic [DIGITS-1:0] digit_sel,
    output logic              ovf_out
);
    bcd_t [DIGITS-1:0] cnt_digits;
    bcd_t [DIGITS-1:0] held_digits;
    logic              cnt_ovf;

    bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .digits   (cnt_digits),
        .ovf      (cnt_ovf)
    );

    bcd_hold_bank #(.DIGITS(DIGITS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_n      (xfer_n),
        .cnt_digits  (cnt_digits),
        .cnt_ovf     (cnt_ovf),
        .held_digits (held_digits),
        .held_ovf    (ovf_out)
    );

    bcd_scan_mux #(.DIGITS(DIGITS), .SLOT_CYCLES(SLOT_CYCLES)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .held_digits (held_digits),
        .bcd_out     (bcd_out),
        .digit_sel   (digit_sel)
    );
endmodule

// File: rtl/bcd_scan_accum_checker.sv
// Module: assertion checker for bcd_scan_accum, bound into every instance.
// It watches the ports plus the internal count digits and overflow flag.
module bcd_scan_accum_checker
    import bcd_scan_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              count_en,
    input logic              xfer_n,
    input logic [3:0]        bcd_out,
    input logic [DIGITS-1:0] digit_sel,
    input logic              ovf_out,
    input bcd_t [DIGITS-1:0] cnt_digits,
    input logic              cnt_ovf
);
    localparam logic [DIGITS-1:0] SEL_TOP = DIGITS'(1) << (DIGITS - 1);

    logic all_nine;
    always_comb begin
        all_nine = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (cnt_digits[i] != BCD_NINE) all_nine = 1'b0;
        end
    end

    // R1: after a reset edge the scan sits in the top slot.
    assert_reset_top_R1: assert property (@(posedge clk)
        !rst_n |=> digit_sel == SEL_TOP);

    // R3: the overflow flag rises only on a step out of all nines.
    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(cnt_ovf)) |-> $past(count_en && all_nine));

    // R3: once set, the overflow flag stays set until reset.
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |=> cnt_ovf);

    // R5, R6: without a transfer outside reset, the held flag does not move.
    assert_hold_ovf_R6: assert property (@(posedge clk)
        (!rst_n || xfer_n) |=> $stable(ovf_out));

    // R7: every strobe change is one step down or a wrap to the top.
    assert_scan_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(digit_sel)) |->
            ((digit_sel == ($past(digit_sel) >> 1)) ||
             ($past(digit_sel) == DIGITS'(1) && digit_sel == SEL_TOP)));

    // R8: exactly one strobe bit is high.
    assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(digit_sel) == 1);

    // R9: the scanned value is a legal BCD digit.
    assert_bcd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_out <= 4'd9);
endmodule

bind bcd_scan_accum bcd_scan_accum_checker #(.DIGITS(DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en   (count_en),
    .xfer_n     (xfer_n),
    .bcd_out    (bcd_out),
    .digit_sel  (digit_sel),
    .ovf_out    (ovf_out),
    .cnt_digits (cnt_digits),
    .cnt_ovf    (cnt_ovf)
);

// File: tb/bcd_scan_accum_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for bcd_scan_accum. Each task drives its own
// stimulus and checks its own results. Inputs change and outputs are
// sampled on falling edges.
module bcd_scan_accum_test;
    localparam int D = 4;
    localparam int S = 4;
    localparam logic [D-1:0] TOP = D'(1) << (D - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         count_en = 1'b0;
    logic         xfer_n = 1'b1;
    logic [3:0]   bcd_out;
    logic [D-1:0] digit_sel;
    logic         ovf_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bcd_scan_accum #(.DIGITS(D), .SLOT_CYCLES(S)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .xfer_n    (xfer_n),
        .bcd_out   (bcd_out),
        .digit_sel (digit_sel),
        .ovf_out   (ovf_out)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL R7 watchdog expired: actual=%0d cycles expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; count_en = 1'b0; xfer_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_n(input int n);
        @(negedge clk);
        count_en = 1'b1;
        repeat (n) @(negedge clk);
        count_en = 1'b0;
    endtask

    task automatic transfer();
        @(negedge clk);
        xfer_n = 1'b0;
        @(negedge clk);
        xfer_n = 1'b1;
    endtask

    // Wait for the first sample of a top slot, then check one full frame.
    task automatic check_frame(input string req, input int value, input int ovf);
        logic [D-1:0] prev;
        int guard;
        int digit;
        prev  = digit_sel;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if ((digit_sel == TOP && prev == D'(1)) || guard > 4 * D * S) break;
            prev = digit_sel;
        end
        chk({req, " ovf_out"}, int'(ovf_out), ovf);
        for (int d = D - 1; d >= 0; d--) begin
            digit = (value / (10 ** d)) % 10;
            for (int s = 0; s < S; s++) begin
                chk({req, " R7 R8 digit_sel"}, int'(digit_sel), int'(D'(1) << d));
                chk({req, " R9 bcd_out"}, int'(bcd_out), digit);
                @(negedge clk);
            end
        end
    endtask

    // R1, R8: the scan starts in the top slot and holds it for S cycles.
    task automatic test_reset_scan();
        do_reset();
        for (int s = 0; s < S; s++) begin
            chk("R1 R8 top slot after reset", int'(digit_sel), int'(TOP));
            @(negedge clk);
        end
        chk("R7 R8 second slot", int'(digit_sel), int'(TOP >> 1));
    endtask

    // R2, R4, R7, R9: a plain count is shown most significant digit first.
    task automatic test_basic_count();
        do_reset();
        count_n(1234);
        transfer();
        check_frame("R2 R4 count 1234", 1234, 0);
    endtask

    // R2: only enabled cycles are counted.
    task automatic test_gapped_enable();
        do_reset();
        count_n(3);
        repeat (2) @(negedge clk);
        count_n(4);
        transfer();
        check_frame("R2 gapped enable", 7, 0);
    endtask

    // R5, R6: reset, a transfer during reset, and counting leave the display alone.
    task automatic test_hold();
        do_reset();
        count_n(1234);
        transfer();
        @(negedge clk);
        rst_n = 1'b0; xfer_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; xfer_n = 1'b1;
        check_frame("R5 transfer during reset", 1234, 0);
        @(negedge clk);
        count_en = 1'b1;
        check_frame("R6 counting without transfer", 1234, 0);
        count_en = 1'b0;
        do_reset();
        check_frame("R6 reset keeps held", 1234, 0);
    endtask

    // R1, R3: wrap at all nines, sticky overflow, reset clears both.
    task automatic test_overflow();
        do_reset();
        count_n(9999);
        transfer();
        check_frame("R3 all nines no overflow", 9999, 0);
        count_n(1);
        transfer();
        check_frame("R3 wrap sets overflow", 0, 1);
        count_n(5);
        transfer();
        check_frame("R3 overflow sticky", 5, 1);
        do_reset();
        transfer();
        check_frame("R1 reset clears count and overflow", 0, 0);
    endtask

    initial begin
        test_reset_scan();
        test_basic_count();
        test_gapped_enable();
        test_hold();
        test_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule